// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

A binary up-counter, four bits wide by default, whose every state change happens on the rising clock edge. A clear input, a parallel-load input with a data bus, and two count enables set what the next edge does. The two enables are a parallel enable and a trickle enable, and both must be high for the counter to advance. Clear wins over load, load wins over counting, and counting wins over holding. All bits take their new value on the same edge, so no bit ripples into another.

The terminal-count flag is high when the count is all ones and the trickle enable is high. To build a wider counter, wire each stage's flag into the trickle enable of the stage above it. Give every stage the same clock, clear, load and parallel enable. The chain then counts as one wide binary counter, and it wraps from all ones to zero.

A separate active-low asynchronous reset puts the count to zero at power-up.

Top module: `sync_cascade_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and `tc_o` is low, whatever the other inputs are.
- R2: At a rising edge with `clr_i` high, `count_o` becomes 0, whatever `load_i`, `data_i` and both enables are.
- R3: At a rising edge with `clr_i` low and `load_i` high, `count_o` takes the value of `data_i`, whatever either enable is.
- R4: At a rising edge with `clr_i` and `load_i` low and both `en_par_i` and `en_trk_i` high, `count_o` increases by one, and all bits change on that same edge.
- R5: At a rising edge with `clr_i` and `load_i` low and either enable low, `count_o` keeps its value.
- R6: `tc_o` is high exactly when `en_trk_i` is high and `count_o` is all ones. It follows these with no clock delay.
- R7: Counting from all ones gives 0 on the next edge.
- R8: Two stages, where the low stage's `tc_o` drives the high stage's `en_trk_i` and all other controls are shared, behave as one 8-bit counter. This counter steps through 0 to 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, active high, highest priority |
| load_i | input | 1 | Synchronous parallel load, active high |
| data_i | input | WIDTH | Parallel load value |
| en_par_i | input | 1 | Parallel count enable |
| en_trk_i | input | 1 | Trickle count enable; also gates `tc_o` |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count: all ones and trickle enable high |

## Verification
The hardest case to reach is the upper stage of a chain advancing. This needs the lower stage at all ones, its trickle enable high, and no clear or load in the same cycle. The high stage is also checked while it sits at all ones and the trickle into it drops, so that its own flag is seen falling. The bench loads every start value and then applies every combination of the four controls to it. Preloading the low stage to all ones makes the carry cross the stage boundary in a single cycle. A full 256-step run then drives the carry through every stage boundary and on to the wrap.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_prio.sv
module cnt_prio
  import cnt_pkg::*;
(
  input  logic    clr_i,
  input  logic    load_i,
  input  logic    en_par_i,
  input  logic    en_trk_i,
  output cnt_op_e op_o
);
  // fixed priority: clear > load > count > hold
  always_comb begin
    if (clr_i)                     op_o = OP_CLR;
    else if (load_i)               op_o = OP_LOAD;
    else if (en_par_i && en_trk_i) op_o = OP_INC;
    else                           op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  always_comb begin
    unique case (op_i)
      OP_CLR:  nxt_o = '0;
      OP_LOAD: nxt_o = data_i;
      OP_INC:  nxt_o = cur_i + One;  // wraps at all ones
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             en_trk_i,
  output logic             tc_o
);
  // per-bit AND chain, one stage per bit
  logic [WIDTH:0] all_ones;
  assign all_ones[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign all_ones[i+1] = all_ones[i] & cur_i[i];
  end
  assign tc_o = en_trk_i & all_ones[WIDTH];
endmodule

// File: rtl/sync_cascade_counter.sv
module sync_cascade_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_par_i,
  input  logic             en_trk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_q, cnt_d;

  cnt_prio u_prio (
    .clr_i    (clr_i),
    .load_i   (load_i),
    .en_par_i (en_par_i),
    .en_trk_i (en_trk_i),
    .op_o     (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op_i   (op),
    .cur_i  (cnt_q),
    .data_i (data_i),
    .nxt_o  (cnt_d)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .cur_i    (cnt_q),
    .en_trk_i (en_trk_i),
    .tc_o     (tc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sync_cascade_counter_chk.sv
module sync_cascade_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             load_i,
  input logic [WIDTH-1:0] data_i,
  input logic             en_par_i,
  input logic             en_trk_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o
);
  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);

  // R3
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_i) |=> count_o == $past(data_i));

  // R4
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && en_par_i && en_trk_i) |=> count_o == $past(count_o) + One);

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !(en_par_i && en_trk_i)) |=> $stable(count_o));

  // R6
  tc_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_trk_i |-> !tc_o);

  // R7
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && en_par_i && tc_o) |=> count_o == '0);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (count_o == '0 && !tc_o);
    end
  end
endmodule

bind sync_cascade_counter sync_cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sync_cascade_counter_bench.sv
`timescale 1ns/1ps
module sync_cascade_counter_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       clr, ld, par, trk;
  logic [3:0] d_lo, d_hi, q_lo, q_hi;
  logic       tc_lo, tc_hi;
  logic [3:0] m_lo, m_hi;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sync_cascade_counter #(.WIDTH(4)) u_sync_cascade_counter (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .load_i(ld), .data_i(d_lo),
    .en_par_i(par), .en_trk_i(trk), .count_o(q_lo), .tc_o(tc_lo));

  sync_cascade_counter #(.WIDTH(4)) u_sync_cascade_counter_hi (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .load_i(ld), .data_i(d_hi),
    .en_par_i(par), .en_trk_i(tc_lo), .count_o(q_hi), .tc_o(tc_hi));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [3:0] cur, input logic c, input logic l,
                                       input logic [3:0] d, input logic p, input logic t);
    if (c)           return 4'd0;
    else if (l)      return d;
    else if (p && t) return cur + 4'd1;
    else             return cur;
  endfunction

  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [3:0] dl, input logic [3:0] dh);
    logic  e_tc_lo, e_tc_hi;
    string tag;
    @(negedge clk);
    clr = c; ld = l; par = p; trk = t; d_lo = dl; d_hi = dh;
    #1;
    e_tc_lo = t && (m_lo == 4'hF);
    e_tc_hi = e_tc_lo && (m_hi == 4'hF);
    chk("R6 tc low stage", int'(tc_lo), int'(e_tc_lo));
    chk("R6 tc high stage", int'(tc_hi), int'(e_tc_hi));
    if (c)           tag = "R2 clear";
    else if (l)      tag = "R3 load";
    else if (p && t) tag = (m_lo == 4'hF) ? "R7 wrap" : "R4 count";
    else             tag = "R5 hold";
    m_lo = model(m_lo, c, l, dl, p, t);
    m_hi = model(m_hi, c, l, dh, p, e_tc_lo);
    @(posedge clk);
    #1;
    chk(tag, int'(q_lo), int'(m_lo));
    chk("R8 high stage", int'(q_hi), int'(m_hi));
  endtask

  initial begin
    rst_ni = 1'b0; clr = 1'b0; ld = 1'b1; par = 1'b1; trk = 1'b1;
    d_lo = 4'd9; d_hi = 4'd6;
    m_lo = 4'd0; m_hi = 4'd0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset count", int'(q_lo), 0);
    chk("R1 reset tc", int'(tc_lo), 0);
    chk("R1 reset high count", int'(q_hi), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // every start value against every control combination
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 16; k++) begin
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'(s), 4'(s ^ 5));
        step(k[3], k[2], k[1], k[0], ~4'(s), 4'(s + 3));
      end
    end

    // high stage at all ones: its tc must follow the trickle into it
    step(1'b0, 1'b1, 1'b0, 1'b0, 4'hE, 4'hF);
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'h0);  // low reaches F, tc_lo goes high
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0);  // trickle low: both hold, tc_hi low

    // 8-bit chain: full run and wrap
    step(1'b1, 1'b1, 1'b1, 1'b1, 4'h7, 4'h7);
    for (int i = 1; i <= 256; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'h0);
      chk("R8 chain value", int'({q_hi, q_lo}), i % 256);
    end

    // pause in the middle of the chain
    step(1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 4'h3);
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 4'h0);
    chk("R5 chain paused", int'({q_hi, q_lo}), 8'h3F);
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'h0);
    chk("R8 carry across stages", int'({q_hi, q_lo}), 8'h40);

    // random control patterns
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1] & r[2], r[3] & r[4], r[5] | r[6], r[7] | r[8], r[12:9], r[16:13]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule